// File: doc/BRIEF.md
# I2C Bus Slave with Own-Address Recognition

This block is a slave-only I2C endpoint. It watches the SCL and SDA lines after a two-flop synchronizer on the system clock and detects START and STOP conditions itself. After a START it takes in the address byte and compares it with a programmable own address. The comparison can use a 7-bit address, or a 10-bit address sent as two bytes. The block can also answer the general call address. A matching address is acknowledged by pulling SDA low during the ninth clock. The R/W bit of the address byte then chooses between receiving and transmitting.

Received bytes are assembled in a shift register and then moved into a holding buffer, which sets an interrupt flag. The shift register can take in the next byte while the host has not yet read the buffer. A byte that completes while the buffer is still unread is refused: the block sends NACK and sets an overflow flag. For transmission the host writes the same buffer. A write during a read transfer goes straight into the shift register as well, and the block shifts the byte out MSB first while SCL is low. It then samples the master's acknowledge and raises the interrupt to ask for the next byte. START and STOP status flags let software tell whether the bus is busy or free.

Top module: `i2c_addr_slave`

## Requirements
- R1: With `ten_bit` low, an address byte whose upper seven bits equal `own_addr[6:0]` is acknowledged (SDA held low through the ninth SCL high phase). Any other address byte is not acknowledged, and the bytes that follow it up to the next START or STOP are ignored: no acknowledge, and no change to `buf_full` or `rd_data`.
- R2: An address byte of 0x00 (the general call, write direction) is acknowledged and its data bytes are received only while `gc_en` is high. With `gc_en` low it is treated as a mismatch.
- R3: SDA falling while SCL is high sets `start_flag` and clears `stop_flag`. SDA rising while SCL is high sets `stop_flag` and clears `start_flag`. Both flags are 0 after reset.
- R4: With `ten_bit` high, a first byte of 11110 followed by `own_addr[9:8]` and R/W=0 is acknowledged. The following byte is acknowledged only when it equals `own_addr[7:0]`. After that, a repeated START with first byte 11110, `own_addr[9:8]` and R/W=1 is acknowledged and starts a transmit transfer.
- R5: In a receive transfer, each completed data byte that finds the buffer empty is acknowledged and copied to `rd_data`, and it sets `buf_full` and `irq`.
- R6: While `buf_full` is set, `rd_data` changes only through a host write. The shift register keeps taking in bits on the bus during that time.
- R7: A data byte that completes while `buf_full` is still set gets NACK and sets `overflow`. The buffer keeps the earlier byte.
- R8: A host write (`wr_buf`) loads `rd_data`. In a transmit transfer the buffered byte is driven onto SDA MSB first. A master ACK on the ninth clock sets `irq`, and a host write made at that point supplies the next byte. A master NACK ends driving until the next START.
- R9: `rd_buf` clears `buf_full`, `irq_clr` clears `irq` and `ovf_clr` clears `overflow`. Each acts in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open drain) |
| own_addr | input | 10 | Own slave address (7-bit mode uses [6:0]) |
| ten_bit | input | 1 | Select 10-bit addressing |
| gc_en | input | 1 | Answer the general call address |
| wr_buf | input | 1 | Host write strobe for the buffer |
| wr_data | input | 8 | Host write data |
| rd_buf | input | 1 | Host has read the buffer, clears `buf_full` |
| irq_clr | input | 1 | Clear interrupt flag |
| ovf_clr | input | 1 | Clear overflow flag |
| rd_data | output | 8 | Buffer contents |
| start_flag | output | 1 | Last bus condition seen was START |
| stop_flag | output | 1 | Last bus condition seen was STOP |
| buf_full | output | 1 | Received byte waiting for the host |
| overflow | output | 1 | A byte was refused because the buffer was full |
| tx_mode | output | 1 | Transmit transfer in progress |
| irq | output | 1 | Interrupt flag |

## Verification
The bench sends a data byte after a mismatched address. A slave that failed to ignore the rest of the transfer would acknowledge that byte or raise `buf_full`. It sends two bytes with no host read between them. A design that overwrote the buffer would show the second byte on `rd_data` and would acknowledge it instead of flagging overflow. The general call is sent both with the enable low and with it high, and a 10-bit exchange is run with the correct low byte and with a wrong one, followed by a repeated-START read. A design that compared only the first byte would acknowledge the wrong low byte. The read path checks the bit order on SDA and the NACK release, since a reversed shift or a slave that kept driving after NACK would show up in the sampled bytes.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [AW-1:0] own_addr,
  input  logic          ten_bit,
  input  logic          gc_en,
  input  logic          wr_buf,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_buf,
  input  logic          irq_clr,
  input  logic          ovf_clr,
  output logic [DW-1:0] rd_data,
  output logic          start_flag,
  output logic          stop_flag,
  output logic          buf_full,
  output logic          overflow,
  output logic          tx_mode,
  output logic          irq
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  typedef enum logic [2:0] {S_IDLE, S_ADDR1, S_ADDR2, S_RX, S_TX, S_SKIP} st_t;
  st_t state;

  logic [1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_q, sda_q;
  logic [DW-1:0] sr, buf_q;
  logic [CW-1:0] bitcnt;
  logic ack_phase, ack_drv, ten_ok;

  assign scl_s = scl_sy[1];
  assign sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i}; sda_sy <= {sda_sy[0], sda_i};
      scl_q <= scl_s; sda_q <= sda_s;
    end

  logic scl_rise, scl_fall, start_det, stop_det, active;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign active    = (state == S_ADDR1) || (state == S_ADDR2) || (state == S_RX) || (state == S_TX);

  logic m7, m10hi, gcall;
  assign m7    = sr[7:1] == own_addr[6:0];
  assign m10hi = sr[7:1] == {5'b11110, own_addr[AW-1:AW-2]};
  assign gcall = gc_en && (sr == '0);

  assign rd_data = buf_q;
  assign tx_mode = state == S_TX;
  assign sda_oe  = ack_drv | (tx_mode & ~ack_phase & ~sr[DW-1]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; sr <= '0; buf_q <= '0; bitcnt <= '0;
      ack_phase <= 1'b0; ack_drv <= 1'b0; ten_ok <= 1'b0;
      start_flag <= 1'b0; stop_flag <= 1'b0;
      buf_full <= 1'b0; overflow <= 1'b0; irq <= 1'b0;
    end else begin
      if (wr_buf) begin
        buf_q <= wr_data;
        if (state == S_TX) sr <= wr_data;
      end
      if (rd_buf)  buf_full <= 1'b0;
      if (irq_clr) irq <= 1'b0;
      if (ovf_clr) overflow <= 1'b0;
      if (start_det) begin
        state <= S_ADDR1; bitcnt <= '0; ack_phase <= 1'b0; ack_drv <= 1'b0;
        start_flag <= 1'b1; stop_flag <= 1'b0;
      end else if (stop_det) begin
        state <= S_IDLE; ack_phase <= 1'b0; ack_drv <= 1'b0; ten_ok <= 1'b0;
        stop_flag <= 1'b1; start_flag <= 1'b0;
      end else if (active && scl_rise) begin
        if (bitcnt != LAST) begin
          if (state != S_TX) sr <= {sr[DW-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else begin
          bitcnt <= '0;
          if (state == S_TX && !ack_drv) begin
            if (sda_s) state <= S_SKIP;
            else       irq <= 1'b1;
          end
        end
      end else if (active && scl_fall) begin
        if (bitcnt == LAST && !ack_phase) begin
          ack_phase <= 1'b1;
          case (state)
            S_ADDR1:
              if (gcall) begin
                ack_drv <= 1'b1; state <= S_RX;
              end else if (!ten_bit) begin
                if (m7) begin
                  ack_drv <= 1'b1;
                  if (sr[0]) begin state <= S_TX; sr <= buf_q; end
                  else state <= S_RX;
                end else state <= S_SKIP;
              end else if (m10hi && !sr[0]) begin
                ack_drv <= 1'b1; state <= S_ADDR2;
              end else if (m10hi && ten_ok) begin
                ack_drv <= 1'b1; state <= S_TX; sr <= buf_q;
              end else state <= S_SKIP;
            S_ADDR2:
              if (sr == own_addr[DW-1:0]) begin
                ack_drv <= 1'b1; state <= S_RX; ten_ok <= 1'b1;
              end else state <= S_SKIP;
            S_RX:
              if (buf_full) overflow <= 1'b1;
              else begin
                buf_q <= sr; buf_full <= 1'b1; irq <= 1'b1; ack_drv <= 1'b1;
              end
            default: ;
          endcase
        end else if (ack_phase && bitcnt == '0) begin
          ack_phase <= 1'b0; ack_drv <= 1'b0;
        end else if (state == S_TX && bitcnt != '0 && bitcnt != LAST) begin
          sr <= {sr[DW-2:0], 1'b0};
        end
      end
    end

  a_r3_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> start_flag && !stop_flag);
  a_r3_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> stop_flag && !start_flag);
  a_r6_hold_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !wr_buf) |=> $stable(rd_data));
  a_r7_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(buf_full));
  a_r1_ack_on_low_scl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drv) |-> !scl_s);
endmodule

// File: tb/i2c_addr_slave_tb.sv
module i2c_addr_slave_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [9:0] own_addr = 10'h05A;
  logic ten_bit = 1'b0, gc_en = 1'b0;
  logic wr_buf = 1'b0, rd_buf = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] wr_data = '0, rd_data;
  logic start_flag, stop_flag, buf_full, overflow, tx_mode, irq;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_addr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .own_addr(own_addr), .ten_bit(ten_bit), .gc_en(gc_en),
    .wr_buf(wr_buf), .wr_data(wr_data), .rd_buf(rd_buf), .irq_clr(irq_clr),
    .ovf_clr(ovf_clr), .rd_data(rd_data), .start_flag(start_flag),
    .stop_flag(stop_flag), .buf_full(buf_full), .overflow(overflow),
    .tx_mode(tx_mode), .irq(irq));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ack7(input logic [7:0] b, input logic [6:0] own, input bit gc);
    return (b[7:1] == own) || (gc && b == 8'h00);
  endfunction

  task automatic bus_start;
    sda_m = 1'b1; tick(10); scl = 1'b1; tick(10);
    sda_m = 1'b0; tick(10); scl = 1'b0; tick(10);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(10); scl = 1'b1; tick(10); sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(10); scl = 1'b1; tick(10); scl = 1'b0; tick(2);
    end
    sda_m = 1'b1; tick(10); scl = 1'b1; tick(10);
    acked = !sda_line;
    scl = 1'b0; tick(10);
  endtask

  task automatic recv_byte(input bit nack, input bit give, input logic [7:0] nxt,
                           output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(10); scl = 1'b1; tick(10); b[i] = sda_line; scl = 1'b0;
    end
    tick(2); sda_m = nack; tick(10); scl = 1'b1; tick(10);
    if (give) host_write(nxt);
    scl = 1'b0; tick(2); sda_m = 1'b1; tick(4);
  endtask

  task automatic host_write(input logic [7:0] d);
    wr_data = d; wr_buf = 1'b1; tick(1); wr_buf = 1'b0; tick(1);
  endtask

  task automatic host_read_clear;
    rd_buf = 1'b1; irq_clr = 1'b1; tick(1); rd_buf = 1'b0; irq_clr = 1'b0; tick(1);
  endtask

  initial begin
    bit a;
    logic [7:0] b;
    logic [7:0] keep;
    void'($urandom(32'd1234));
    tick(5); rst_n = 1'b1; tick(5);
    check(!start_flag && !stop_flag && !buf_full && !overflow && !irq && !sda_oe,
          "R3 reset state", {start_flag, stop_flag, buf_full, overflow, irq, sda_oe}, 0);

    bus_start;
    check(start_flag && !stop_flag, "R3 start flag", {start_flag, stop_flag}, 2);
    send_byte({7'h5A, 1'b0}, a);
    check(a, "R1 own address acked", a, 1);
    send_byte(8'hA5, a);
    check(a && rd_data == 8'hA5 && buf_full && irq, "R5 byte to buffer",
          {a, buf_full, irq, rd_data}, {3'b111, 8'hA5});
    bus_stop;
    check(stop_flag && !start_flag, "R3 stop flag", {start_flag, stop_flag}, 1);
    host_read_clear;
    check(!buf_full && !irq, "R9 read and irq clear", {buf_full, irq}, 0);

    bus_start;
    send_byte({7'h33, 1'b0}, a);
    check(!a, "R1 mismatch not acked", a, 0);
    send_byte(8'h77, a);
    check(!a && !buf_full && rd_data == 8'hA5, "R1 ignored after mismatch",
          {a, buf_full, rd_data}, {2'b00, 8'hA5});
    bus_stop;

    bus_start; send_byte(8'h00, a); bus_stop;
    check(!a, "R2 general call off", a, 0);
    gc_en = 1'b1;
    bus_start; send_byte(8'h00, a);
    check(a, "R2 general call on", a, 1);
    send_byte(8'h4C, a);
    check(a && rd_data == 8'h4C, "R2 general call data", rd_data, 8'h4C);
    bus_stop; host_read_clear; gc_en = 1'b0;

    bus_start; send_byte({7'h5A, 1'b0}, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    check(!a && overflow, "R7 second byte refused", {a, overflow}, 1);
    check(rd_data == 8'h11 && buf_full, "R6 earlier byte kept", rd_data, 8'h11);
    bus_stop;
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0; tick(1);
    check(!overflow, "R9 overflow clear", overflow, 0);
    host_read_clear;

    ten_bit = 1'b1; own_addr = 10'h2B7;
    bus_start; send_byte(8'hF4, a);
    check(a, "R4 ten-bit first byte", a, 1);
    send_byte(8'hB6, a);
    check(!a, "R4 wrong low byte", a, 0);
    bus_stop;
    bus_start; send_byte(8'hF4, a); send_byte(8'hB7, a);
    check(a, "R4 ten-bit low byte", a, 1);
    send_byte(8'h9E, a);
    check(a && rd_data == 8'h9E, "R4 ten-bit data", rd_data, 8'h9E);
    host_read_clear;
    host_write(8'hC3);
    check(rd_data == 8'hC3, "R8 host write loads buffer", rd_data, 8'hC3);
    bus_start; send_byte(8'hF5, a);
    check(a && tx_mode, "R4 ten-bit read after restart", {a, tx_mode}, 3);
    recv_byte(1'b0, 1'b1, 8'h5E, b);
    check(b == 8'hC3, "R8 first byte MSB first", b, 8'hC3);
    check(irq, "R8 master ack sets irq", irq, 1);
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
    recv_byte(1'b1, 1'b0, 8'h00, b);
    check(b == 8'h5E, "R8 second byte", b, 8'h5E);
    tick(10);
    check(!sda_oe && !tx_mode, "R8 released after nack", {sda_oe, tx_mode}, 0);
    bus_stop;

    ten_bit = 1'b0;
    for (int k = 0; k < 24; k++) begin
      logic [7:0] ab, db;
      bit ea;
      own_addr = {3'b000, 7'($urandom_range(1, 127))};
      gc_en = 1'($urandom);
      case ($urandom_range(0, 2))
        0: ab = {own_addr[6:0], 1'b0};
        1: ab = 8'h00;
        default: ab = {7'($urandom), 1'b0};
      endcase
      db = 8'($urandom);
      ea = exp_ack7(ab, own_addr[6:0], gc_en);
      keep = rd_data;
      bus_start; send_byte(ab, a);
      check(a == ea, "R1 random address", a, ea);
      send_byte(db, a);
      if (ea) check(a && rd_data == db && buf_full, "R5 random data", rd_data, db);
      else    check(!a && !buf_full && rd_data == keep, "R1 random ignored", rd_data, keep);
      bus_stop; host_read_clear;
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule